// File: doc/BRIEF.md
# Predicated Instruction Decoder with Registered Issue

This block sits at the front of a single-issue 8-bit accumulator core that uses a 16-bit fixed-length instruction word. Each cycle it takes one instruction word and the current processor flags. It separates the word into a predicate, a primary opcode and an operand byte, and works out the addressing class. For operand-less instructions it also decodes the low byte as a secondary opcode. It then resolves the predicate against the flags. The result goes to a registered issue stage as a one-hot operation select, a class vector, the operand byte and a set of write and access strobes.

When the predicate fails, the instruction turns into a no-operation. All write strobes drop and a not-taken indication is raised for that issue slot. An unknown secondary opcode is also issued as a no-operation and is marked illegal. The flags are used exactly as presented in the same cycle as the instruction. Nothing is forwarded from the instruction being decoded.

Top module: `pred_decoder`

## Requirements
- R1: The instruction word holds the predicate in bits 15:13, the primary opcode in bits 12:8 and the operand byte in bits 7:0. For every valid input, `iss_valid` is 1 and `iss_operand` equals bits 7:0.
- R2: `iss_cls` is one-hot. Bit 0 means implied (primary 0), bit 1 means immediate (primary 1 to 8) and bit 2 means absolute (primary 9 to 31).
- R3: The predicate is checked against `flags` (bit 3 N, bit 2 Z, bit 1 C, bit 0 V). The codes are: 0 always; 1 when V is set; 2 when C is set; 3 when C is clear; 4 when Z is set; 5 when Z is clear; 6 when N is set; 7 when N is clear. Only the flags presented in the same cycle as the instruction count.
- R4: `iss_exec` is 1 when the predicate holds and the instruction is legal. When the predicate fails, `iss_skip` is 1, `iss_exec` is 0, `iss_op` has only bit 0 (no-operation) set, and every strobe is 0.
- R5: The `iss_op` bit index follows this operation numbering: nop 0, brk 1, wai 2, clv 3, sec 4, clc 5, sei 6, cli 7, lsl 8, lsr 9, rol 10, ror 11, pha 12, pla 13, php 14, plp 15, rti 16, rts 17, tas 18, tsa 19, add 20, adc 21, and 22, eor 23, ior 24, cmp 25, cpc 26, lda 27, sub 28, sbc 29, inc 30, dec 31, relative jump 32, indirect jump 33, jsr 34, xch 35, indirect lda 36, sta 37, indirect sta 38. For the implied class, a low byte of 0 to 19 selects the operation with that same number.
- R6: Immediate primaries 1 to 7 select add, adc, and, eor, ior, cmp, cpc. Primary 8 selects lda.
- R7: Absolute primaries 9 to 15 select add through cpc. Primaries 16 to 19 select sub, sbc, inc, dec. Primaries 20 to 23 select lsl, lsr, rol, ror. Primaries 24 to 27 select relative jump, indirect jump, jsr, xch. Primaries 28 to 31 select lda, indirect lda, sta, indirect sta.
- R8: An implied instruction with a low byte above 19 sets `iss_illegal` (whatever the predicate) and issues as a no-operation with `iss_exec` 0 and all strobes 0.
- R9: For an executing instruction, `iss_acc_wr` is 1 for: implied shifts and rotates, pla, tsa, add, adc, and, eor, ior, sub, sbc, lda, indirect lda and xch.
- R10: For an executing instruction, `iss_flag_wr` is 1 for: clv, sec, clc, sei, cli, plp, rti, pla, all shifts and rotates, add, adc, and, eor, ior, cmp, cpc, sub, sbc, inc, dec, lda and indirect lda.
- R11: For an executing instruction, `iss_mem_rd` is 1 for pla, plp, rti, rts and for every absolute operation except relative jump, jsr and sta. `iss_mem_wr` is 1 for brk, pha, php, jsr, xch, sta, indirect sta, inc, dec and the absolute shifts and rotates.
- R12: For an executing instruction, `iss_pc_wr` is 1 for brk, rti, rts, relative jump, indirect jump and jsr.
- R13: Outputs change one clock edge after the input is sampled. A cycle with `instr_valid` low issues all-zero outputs.
- R14: While `rst_n` is low, every output is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| instr_valid | input | 1 | Instruction word present this cycle |
| instr | input | 16 | Instruction word |
| flags | input | 4 | Current flags {N,Z,C,V} |
| iss_valid | output | 1 | Issue slot occupied |
| iss_exec | output | 1 | Instruction executes |
| iss_skip | output | 1 | Predicate false, not taken |
| iss_illegal | output | 1 | Unknown implied secondary opcode |
| iss_cls | output | 3 | One-hot class {absolute, immediate, implied} |
| iss_op | output | 39 | One-hot operation select |
| iss_operand | output | 8 | Operand byte |
| iss_acc_wr | output | 1 | Accumulator write strobe |
| iss_flag_wr | output | 1 | Flag write strobe |
| iss_mem_rd | output | 1 | Memory read strobe |
| iss_mem_wr | output | 1 | Memory write strobe |
| iss_pc_wr | output | 1 | Program counter write strobe |

## Verification
A wrong internal value in this block has only one place to show up: the issue register, exactly one edge after the offending word. A mis-resolved predicate shows as the wrong `iss_exec` and `iss_skip` pair, together with strobes that should have been suppressed or should have fired. A wrong table entry shows as a misplaced `iss_op` bit or a wrong strobe for one primary or secondary code. For that reason, every predicate code is swept against all sixteen flag combinations, every primary code is driven, and all 256 implied low bytes are driven. Each issue slot is compared field by field on the cycle after it is applied.

// File: rtl/pdec_pkg.sv
package pdec_pkg;
    localparam int INSTR_W   = 16;
    localparam int COND_W    = 3;
    localparam int OPC_W     = 5;
    localparam int OPND_W    = 8;
    localparam int FLAG_W    = 4;
    localparam int CLS_W     = 3;
    localparam int IMPL_LAST = 19;
    localparam int IMM_LAST  = 8;
    localparam int NUM_OPS   = 39;
    localparam int OP_IDX_W  = $clog2(NUM_OPS);

    localparam int CLS_IMPL = 0;
    localparam int CLS_IMM  = 1;
    localparam int CLS_ABS  = 2;

    typedef enum logic [OP_IDX_W-1:0] {
        OP_NOP, OP_BRK, OP_WAI, OP_CLV, OP_SEC, OP_CLC, OP_SEI, OP_CLI,
        OP_LSL, OP_LSR, OP_ROL, OP_ROR, OP_PHA, OP_PLA, OP_PHP, OP_PLP,
        OP_RTI, OP_RTS, OP_TAS, OP_TSA,
        OP_ADD, OP_ADC, OP_AND, OP_EOR, OP_IOR, OP_CMP, OP_CPC, OP_LDA,
        OP_SUB, OP_SBC, OP_INC, OP_DEC,
        OP_JMPR, OP_JMPI, OP_JSR, OP_XCH, OP_LDAI, OP_STA, OP_STAI
    } op_e;

    typedef struct packed {
        logic               acc_wr;
        logic               flag_wr;
        logic               mem_rd;
        logic               mem_wr;
        logic               pc_wr;
    } strobe_t;

    typedef struct packed {
        logic               valid;
        logic               exec;
        logic               skip;
        logic               illegal;
        logic [CLS_W-1:0]   cls;
        logic [NUM_OPS-1:0] op;
        logic [OPND_W-1:0]  operand;
        strobe_t            stb;
    } issue_t;
endpackage

// File: rtl/pdec_field_split.sv
module pdec_field_split
    import pdec_pkg::*;
(
    input  logic [INSTR_W-1:0] word,
    output logic [COND_W-1:0]  cond,
    output logic [OPC_W-1:0]   primary,
    output logic [OPND_W-1:0]  low,
    output logic [CLS_W-1:0]   cls
);
    assign cond    = word[INSTR_W-1 -: COND_W];
    assign primary = word[OPND_W +: OPC_W];
    assign low     = word[OPND_W-1:0];

    always_comb begin
        cls = '0;
        if (primary == '0)
            cls[CLS_IMPL] = 1'b1;
        else if (int'(primary) <= IMM_LAST)
            cls[CLS_IMM] = 1'b1;
        else
            cls[CLS_ABS] = 1'b1;
    end
endmodule

// File: rtl/pdec_cond_eval.sv
module pdec_cond_eval
    import pdec_pkg::*;
(
    input  logic [COND_W-1:0] cond,
    input  logic [FLAG_W-1:0] flags,
    output logic              pass
);
    logic [1:0] sel;
    assign sel = cond[2:1];

    always_comb begin
        if (sel == 2'b00)
            pass = cond[0] ? flags[0] : 1'b1;
        else
            pass = flags[sel] ^ cond[0];
    end
endmodule

// File: rtl/pdec_op_map.sv
module pdec_op_map
    import pdec_pkg::*;
(
    input  logic [OPC_W-1:0]  primary,
    input  logic [OPND_W-1:0] low,
    input  logic [CLS_W-1:0]  cls,
    output op_e               op,
    output logic              illegal
);
    logic [OP_IDX_W-1:0] p6;
    assign p6 = OP_IDX_W'(primary);

    always_comb begin
        op      = OP_NOP;
        illegal = 1'b0;
        if (cls[CLS_IMPL]) begin
            if (int'(low) <= IMPL_LAST)
                op = op_e'(low[OP_IDX_W-1:0]);
            else
                illegal = 1'b1;
        end else if (cls[CLS_IMM]) begin
            if (int'(primary) == IMM_LAST)
                op = OP_LDA;
            else
                op = op_e'(p6 + OP_IDX_W'(19));
        end else begin
            case (primary)
                5'd9, 5'd10, 5'd11, 5'd12, 5'd13, 5'd14, 5'd15:
                    op = op_e'(p6 + OP_IDX_W'(11));
                5'd16, 5'd17, 5'd18, 5'd19:
                    op = op_e'(p6 + OP_IDX_W'(12));
                5'd20, 5'd21, 5'd22, 5'd23:
                    op = op_e'(p6 - OP_IDX_W'(12));
                5'd24, 5'd25, 5'd26, 5'd27:
                    op = op_e'(p6 + OP_IDX_W'(8));
                5'd28:   op = OP_LDA;
                5'd29:   op = OP_LDAI;
                5'd30:   op = OP_STA;
                default: op = OP_STAI;
            endcase
        end
    end
endmodule

// File: rtl/pdec_strobe_gen.sv
module pdec_strobe_gen
    import pdec_pkg::*;
(
    input  op_e     op,
    input  logic    is_abs,
    output strobe_t stb
);
    always_comb begin
        stb        = '0;
        stb.mem_rd = is_abs;
        case (op)
            OP_BRK: begin stb.pc_wr = 1'b1; stb.mem_wr = 1'b1; end
            OP_CLV, OP_SEC, OP_CLC, OP_SEI, OP_CLI:
                stb.flag_wr = 1'b1;
            OP_LSL, OP_LSR, OP_ROL, OP_ROR: begin
                stb.flag_wr = 1'b1;
                stb.acc_wr  = !is_abs;
                stb.mem_wr  = is_abs;
            end
            OP_PHA, OP_PHP: stb.mem_wr = 1'b1;
            OP_PLA: begin
                stb.acc_wr = 1'b1; stb.flag_wr = 1'b1; stb.mem_rd = 1'b1;
            end
            OP_PLP: begin stb.flag_wr = 1'b1; stb.mem_rd = 1'b1; end
            OP_RTI: begin
                stb.flag_wr = 1'b1; stb.pc_wr = 1'b1; stb.mem_rd = 1'b1;
            end
            OP_RTS: begin stb.pc_wr = 1'b1; stb.mem_rd = 1'b1; end
            OP_TSA: stb.acc_wr = 1'b1;
            OP_ADD, OP_ADC, OP_AND, OP_EOR, OP_IOR, OP_SUB, OP_SBC,
            OP_LDA, OP_LDAI: begin
                stb.acc_wr = 1'b1; stb.flag_wr = 1'b1;
            end
            OP_CMP, OP_CPC: stb.flag_wr = 1'b1;
            OP_INC, OP_DEC: begin stb.flag_wr = 1'b1; stb.mem_wr = 1'b1; end
            OP_JMPR: begin stb.pc_wr = 1'b1; stb.mem_rd = 1'b0; end
            OP_JMPI: stb.pc_wr = 1'b1;
            OP_JSR: begin
                stb.pc_wr = 1'b1; stb.mem_wr = 1'b1; stb.mem_rd = 1'b0;
            end
            OP_XCH: begin stb.acc_wr = 1'b1; stb.mem_wr = 1'b1; end
            OP_STA: begin stb.mem_wr = 1'b1; stb.mem_rd = 1'b0; end
            OP_STAI: stb.mem_wr = 1'b1;
            default: ;
        endcase
    end
endmodule

// File: rtl/pred_decoder.sv
module pred_decoder
    import pdec_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  instr_valid,
    input  logic [INSTR_W-1:0]    instr,
    input  logic [FLAG_W-1:0]     flags,
    output logic                  iss_valid,
    output logic                  iss_exec,
    output logic                  iss_skip,
    output logic                  iss_illegal,
    output logic [CLS_W-1:0]      iss_cls,
    output logic [NUM_OPS-1:0]    iss_op,
    output logic [OPND_W-1:0]     iss_operand,
    output logic                  iss_acc_wr,
    output logic                  iss_flag_wr,
    output logic                  iss_mem_rd,
    output logic                  iss_mem_wr,
    output logic                  iss_pc_wr
);
    logic [COND_W-1:0]   cond;
    logic [OPC_W-1:0]    primary;
    logic [OPND_W-1:0]   low;
    logic [CLS_W-1:0]    cls;
    logic                pass;
    op_e                 op_sel;
    logic                bad_code;
    strobe_t             stb_raw;
    logic [OP_IDX_W-1:0] op_bits;
    logic [NUM_OPS-1:0]  op_onehot;
    issue_t              issue_d;
    issue_t              issue_q;

    pdec_field_split u_split (
        .word    (instr),
        .cond    (cond),
        .primary (primary),
        .low     (low),
        .cls     (cls)
    );

    pdec_cond_eval u_cond (
        .cond  (cond),
        .flags (flags),
        .pass  (pass)
    );

    pdec_op_map u_map (
        .primary (primary),
        .low     (low),
        .cls     (cls),
        .op      (op_sel),
        .illegal (bad_code)
    );

    pdec_strobe_gen u_stb (
        .op     (op_sel),
        .is_abs (cls[CLS_ABS]),
        .stb    (stb_raw)
    );

    assign op_bits = op_sel;

    for (genvar i = 0; i < NUM_OPS; i++) begin : g_onehot
        assign op_onehot[i] = (op_bits == OP_IDX_W'(i));
    end

    always_comb begin
        issue_d = '0;
        if (instr_valid) begin
            issue_d.valid   = 1'b1;
            issue_d.cls     = cls;
            issue_d.operand = low;
            issue_d.illegal = bad_code;
            issue_d.skip    = !pass;
            issue_d.exec    = pass && !bad_code;
            if (issue_d.exec) begin
                issue_d.op  = op_onehot;
                issue_d.stb = stb_raw;
            end else begin
                issue_d.op[OP_NOP] = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            issue_q <= '0;
        else
            issue_q <= issue_d;
    end

    assign iss_valid   = issue_q.valid;
    assign iss_exec    = issue_q.exec;
    assign iss_skip    = issue_q.skip;
    assign iss_illegal = issue_q.illegal;
    assign iss_cls     = issue_q.cls;
    assign iss_op      = issue_q.op;
    assign iss_operand = issue_q.operand;
    assign iss_acc_wr  = issue_q.stb.acc_wr;
    assign iss_flag_wr = issue_q.stb.flag_wr;
    assign iss_mem_rd  = issue_q.stb.mem_rd;
    assign iss_mem_wr  = issue_q.stb.mem_wr;
    assign iss_pc_wr   = issue_q.stb.pc_wr;
endmodule

// File: rtl/pdec_checker.sv
module pdec_checker
    import pdec_pkg::*;
(
    input logic                  clk,
    input logic                  rst_n,
    input logic                  instr_valid,
    input logic [INSTR_W-1:0]    instr,
    input logic [FLAG_W-1:0]     flags,
    input logic                  iss_valid,
    input logic                  iss_exec,
    input logic                  iss_skip,
    input logic                  iss_illegal,
    input logic [CLS_W-1:0]      iss_cls,
    input logic [NUM_OPS-1:0]    iss_op,
    input logic [OPND_W-1:0]     iss_operand,
    input logic                  iss_acc_wr,
    input logic                  iss_flag_wr,
    input logic                  iss_mem_rd,
    input logic                  iss_mem_wr,
    input logic                  iss_pc_wr
);
    logic [4:0] any_stb;
    assign any_stb = {iss_acc_wr, iss_flag_wr, iss_mem_rd, iss_mem_wr, iss_pc_wr};

    AST_OPERAND_PASS: assert property (@(posedge clk) disable iff (!rst_n)
        instr_valid |=> (iss_valid && iss_operand == $past(instr[7:0]))); // R1

    AST_CLASS_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
        iss_valid |-> $countones(iss_cls) == 1); // R2

    AST_ZERO_CLEAR_TAKEN: assert property (@(posedge clk) disable iff (!rst_n)
        (instr_valid && instr[15:13] == 3'b101 && !flags[2] && instr[12:8] != 5'd0)
        |=> iss_exec); // R3

    AST_SKIP_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        iss_skip |-> (!iss_exec && any_stb == 5'd0 && iss_op == NUM_OPS'(1))); // R4

    AST_OP_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
        iss_valid |-> $countones(iss_op) == 1); // R5

    AST_ILLEGAL_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        iss_illegal |-> (!iss_exec && any_stb == 5'd0 && iss_cls[0])); // R8

    AST_IDLE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        !instr_valid |=> (!iss_valid && iss_op == '0 && any_stb == 5'd0)); // R13

    AST_STROBE_NEEDS_EXEC: assert property (@(posedge clk) disable iff (!rst_n)
        (any_stb != 5'd0) |-> iss_exec); // R4
endmodule

bind pred_decoder pdec_checker u_pdec_checker (.*);

// File: tb/pred_decoder_test.sv
module pred_decoder_test;
    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 20000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        instr_valid = 1'b0;
    logic [15:0] instr = '0;
    logic [3:0]  flags = '0;
    logic        iss_valid, iss_exec, iss_skip, iss_illegal;
    logic [2:0]  iss_cls;
    logic [38:0] iss_op;
    logic [7:0]  iss_operand;
    logic        iss_acc_wr, iss_flag_wr, iss_mem_rd, iss_mem_wr, iss_pc_wr;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    pred_decoder uut (
        .clk(clk), .rst_n(rst_n), .instr_valid(instr_valid), .instr(instr),
        .flags(flags), .iss_valid(iss_valid), .iss_exec(iss_exec),
        .iss_skip(iss_skip), .iss_illegal(iss_illegal), .iss_cls(iss_cls),
        .iss_op(iss_op), .iss_operand(iss_operand), .iss_acc_wr(iss_acc_wr),
        .iss_flag_wr(iss_flag_wr), .iss_mem_rd(iss_mem_rd),
        .iss_mem_wr(iss_mem_wr), .iss_pc_wr(iss_pc_wr)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h (instr %04h flags %0h)",
                     req, act, exp, instr, flags);
        end
    endtask

    function automatic int exp_idx(input int p, input int low);
        if (p == 0)  return low;
        if (p <= 7)  return 19 + p;
        if (p == 8)  return 27;
        if (p <= 15) return p + 11;
        if (p <= 19) return p + 12;
        if (p <= 23) return p - 12;
        if (p <= 27) return p + 8;
        if (p == 28) return 27;
        if (p == 29) return 36;
        return p + 7;
    endfunction

    function automatic bit cond_true(input int c, input logic [3:0] f);
        case (c)
            0: return 1'b1;
            1: return f[0];
            2: return f[1];
            3: return !f[1];
            4: return f[2];
            5: return !f[2];
            6: return f[3];
            default: return !f[3];
        endcase
    endfunction

    // Applies one word, waits one edge, then compares every output field.
    task automatic step(input logic [15:0] w, input logic [3:0] f);
        int c, p, lo, idx;
        bit abs_c, imp_c, ill, taken, ex;
        bit e_acc, e_flg, e_rd, e_wr, e_pc;
        logic [38:0] e_op;
        instr = w; flags = f; instr_valid = 1'b1;
        c = int'(w[15:13]); p = int'(w[12:8]); lo = int'(w[7:0]);
        imp_c = (p == 0); abs_c = (p >= 9);
        ill   = imp_c && lo > 19;
        taken = cond_true(c, f);
        ex    = taken && !ill;
        idx   = exp_idx(p, lo);
        e_op  = '0;
        if (ex) e_op[idx] = 1'b1; else e_op[0] = 1'b1;
        e_acc = ex && ((imp_c && idx inside {[8:11]}) ||
                       idx inside {13, 19, 20, 21, 22, 23, 24, 27, 28, 29, 35, 36});
        e_flg = ex && (idx inside {[3:11], 13, 15, 16, [20:31], 36});
        e_rd  = ex && (idx inside {13, 15, 16, 17} ||
                       (abs_c && !(idx inside {32, 34, 37})));
        e_wr  = ex && (idx inside {1, 12, 14, 34, 35, 37, 38} ||
                       (abs_c && idx inside {[8:11], 30, 31}));
        e_pc  = ex && (idx inside {1, 16, 17, 32, 33, 34});
        @(negedge clk);
        instr_valid = 1'b0;
        chk("R1 valid", 64'(iss_valid), 64'd1);
        chk("R1 operand", 64'(iss_operand), 64'(w[7:0]));
        chk("R2 class", 64'(iss_cls), 64'({abs_c, !imp_c && !abs_c, imp_c}));
        chk("R3 exec", 64'(iss_exec), 64'(ex));
        chk("R4 skip", 64'(iss_skip), 64'(!taken));
        if (imp_c)      chk("R5 op implied", 64'(iss_op), 64'(e_op));
        else if (!abs_c) chk("R6 op immediate", 64'(iss_op), 64'(e_op));
        else            chk("R7 op absolute", 64'(iss_op), 64'(e_op));
        chk("R8 illegal", 64'(iss_illegal), 64'(ill));
        chk("R9 acc_wr", 64'(iss_acc_wr), 64'(e_acc));
        chk("R10 flag_wr", 64'(iss_flag_wr), 64'(e_flg));
        chk("R11 mem_rd", 64'(iss_mem_rd), 64'(e_rd));
        chk("R11 mem_wr", 64'(iss_mem_wr), 64'(e_wr));
        chk("R12 pc_wr", 64'(iss_pc_wr), 64'(e_pc));
    endtask

    task automatic check_all_zero(input string req);
        chk(req, 64'({iss_valid, iss_exec, iss_skip, iss_illegal, iss_cls,
                      iss_acc_wr, iss_flag_wr, iss_mem_rd, iss_mem_wr, iss_pc_wr}), 64'd0);
        chk(req, 64'(iss_op), 64'd0);
        chk(req, 64'(iss_operand), 64'd0);
    endtask

    initial begin
        #(CLK_PERIOD * 3 + CLK_PERIOD / 2);
        instr = 16'h2A5F; instr_valid = 1'b1; flags = 4'hF;
        #1;
        check_all_zero("R14 reset");
        @(negedge clk);
        instr_valid = 1'b0;
        rst_n = 1'b1;
        @(negedge clk);
        check_all_zero("R13 idle after reset");

        // Predicate sweep: every code against every flag combination.
        for (int c = 0; c < 8; c++)
            for (int f = 0; f < 16; f++) begin
                step({3'(c), 5'd1, 8'hA5}, 4'(f));
                step({3'(c), 5'd30, 8'h3C}, 4'(f));
            end

        // Every primary code with a spread of operand bytes.
        for (int p = 1; p < 32; p++) begin
            step({3'd0, 5'(p), 8'h00}, 4'h0);
            step({3'd0, 5'(p), 8'h5A}, 4'hA);
            step({3'd0, 5'(p), 8'hFF}, 4'h5);
        end

        // All implied secondary codes, taken and not taken.
        for (int lo = 0; lo < 256; lo++)
            step({3'd0, 5'd0, 8'(lo)}, 4'h0);
        for (int lo = 0; lo < 24; lo++)
            step({3'd1, 5'd0, 8'(lo)}, 4'h0);

        // R3: flags changing one cycle later leave the issued result alone.
        step({3'd4, 5'd28, 8'h11}, 4'b0100);
        flags = 4'b0000;
        @(negedge clk);
        check_all_zero("R13 idle slot");

        // R13: back-to-back words each appear exactly one edge later.
        instr = {3'd0, 5'd8, 8'h77}; flags = 4'h0; instr_valid = 1'b1;
        @(negedge clk);
        instr = {3'd2, 5'd8, 8'h88}; flags = 4'h0;
        chk("R13 latency first", 64'({iss_exec, iss_operand}), 64'({1'b1, 8'h77}));
        @(negedge clk);
        instr_valid = 1'b0;
        chk("R13 latency second", 64'({iss_skip, iss_operand}), 64'({1'b1, 8'h88}));
        @(negedge clk);
        check_all_zero("R13 drain");

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        for (int i = 0; i < WATCHDOG; i++) begin
            @(posedge clk);
            if (done) break;
        end
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end
endmodule